// File: doc/BRIEF.md
# Incremental Fourth-Order Sinc Decimator

This block turns the one-bit stream of an incremental sigma-delta modulator into a single signed word per conversion. A synchronous start pulse clears every integrator and comb register. The block then takes in exactly 4·R modulator bits, one on each cycle where the oversampling enable is high. After the last of those bits it raises a one-cycle done strobe together with the settled output of a fourth-order cascaded integrator-comb filter, whose response is [(1 − z^-R)/(1 − z^-1)]^4. No state is kept from one conversion to the next. Bits that arrive after the strobe are ignored until the next start.

The ratio R is a power of two, given as log2(R) on a port and captured when the start pulse arrives. The maximum ratio is a parameter, 512 by default. The integrators use modulo two's-complement arithmetic that is 4·log2(Rmax)+2 bits wide. The comb output is scaled so that full scale does not depend on R. The 24-bit result is the top bits of the scaled value, truncated toward minus infinity.

Top module: `sinc4_incremental_decimator`

## Requirements
- R1: After reset, `resultValid` is 0 and `result` is 0.
- R2: A `modBit` of 1 counts as the value +1 and a `modBit` of 0 counts as −1.
- R3: `resultValid` is high for exactly one clock cycle: the cycle right after the clock edge that captures the 4·R-th enabled bit following a start. It is never high earlier in the conversion.
- R4: A stream of all ones gives `result` = +2^22 (0x400000). A stream of all zeros gives −2^22 (0xC00000). This holds for every supported ratio.
- R5: `result` equals floor(2^22 · y / R^4). Here y = Σ h[k]·x[4R−1−k], x[n] is the n-th enabled bit after the start mapped to ±1, and h is the impulse response of four cascaded length-R boxcar sums (the sum of h is R^4).
- R6: `convStart` clears all filter state, including during a conversion that has not finished. The next result depends only on bits that arrive after that start.
- R7: A cycle with `sampleEn` low consumes no bit, so the value of `modBit` in that cycle has no effect.
- R8: `ratioLog2` is captured on the `convStart` cycle and must lie between 1 and MAX_LOG2 (default 9). Changes to it later in the conversion have no effect.
- R9: After the done strobe and before the next start, enabled bits neither raise `resultValid` nor change `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convStart | input | 1 | Synchronous conversion start; clears the filter |
| sampleEn | input | 1 | High on cycles that carry a modulator bit |
| modBit | input | 1 | Modulator output, 1 for +1 and 0 for −1 |
| ratioLog2 | input | $clog2(MAX_LOG2+1) | log2 of the decimation ratio, captured at start |
| result | output | OUT_W (24) | Signed conversion result, held until the next strobe |
| resultValid | output | 1 | One-cycle done strobe |

## Verification
The assertions assume that `ratioLog2` lies within the legal range whenever `convStart` is high. They also assume that start and enable are used as the requirements describe. Under those assumptions, the done strobe is a single cycle, the sample counter never passes 4·R−1, and the result never exceeds full scale. The bench captures every ratio it applies inside that range and only changes `ratioLog2` outside the start cycle. It drives inputs on the falling edge, so no bit lands on the same edge as a start. Expected results come from a convolution with the boxcar-cubed impulse response that the bench builds itself.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
  // Strobes issued by the control module to the datapath
  typedef struct packed {
    logic clear;   // wipe integrators and comb delays
    logic accum;   // take one modulator bit into the integrators
    logic decim;   // decimated tick: advance the comb chain
    logic finish;  // last bit of the conversion: register the result
  } ctlStrobes_t;
endpackage

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl
  import sinc4_pkg::*;
#(
  parameter int MAX_LOG2 = 9,
  parameter int MIN_LOG2 = 1,
  parameter int LW = 4,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          sampleEn,
  input  logic [LW-1:0] ratioLog2,
  output ctlStrobes_t   strobe,
  output logic [SW-1:0] normShift
);
  localparam int CW = MAX_LOG2 + 2;

  logic          running;
  logic [CW-1:0] sampleCount;
  logic [LW-1:0] ratioHeld;
  logic [CW-1:0] lastCount;
  logic [CW-1:0] tickMask;

  always_comb begin
    lastCount = (CW'(4) << ratioHeld) - CW'(1);
    tickMask  = (CW'(1) << ratioHeld) - CW'(1);
    normShift = SW'(4 * (MAX_LOG2 - int'(ratioHeld)));
    strobe.clear  = start;
    strobe.accum  = running && sampleEn && !start;
    strobe.decim  = strobe.accum && ((sampleCount & tickMask) == tickMask);
    strobe.finish = strobe.accum && (sampleCount == lastCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running     <= 1'b0;
      sampleCount <= '0;
      ratioHeld   <= LW'(MAX_LOG2);
    end else if (start) begin
      running     <= 1'b1;
      sampleCount <= '0;
      ratioHeld   <= ratioLog2;
    end else if (strobe.accum) begin
      sampleCount <= sampleCount + CW'(1);
      if (strobe.finish) running <= 1'b0;
    end
  end

  // R8: the captured ratio must be a supported one
  p_ratio_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (int'(ratioLog2) >= MIN_LOG2 && int'(ratioLog2) <= MAX_LOG2));

  // R3: the counter never runs past the final sample of a conversion
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (sampleCount <= lastCount));

  // R9: once the last bit is taken, the block stays idle until a new start
  p_idle_after_finish_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !running);
endmodule

// File: rtl/sinc4_datapath.sv
module sinc4_datapath
  import sinc4_pkg::*;
#(
  parameter int W = 38,
  parameter int OUT_W = 24,
  parameter int SW = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobe,
  input  logic [SW-1:0]    normShift,
  input  logic             bitIn,
  output logic [OUT_W-1:0] result,
  output logic             done
);
  localparam int ORDER = 4;
  localparam logic signed [W-1:0] PLUS_ONE  = W'(1);
  localparam logic signed [W-1:0] MINUS_ONE = -W'(1);

  logic signed [W-1:0] integ     [ORDER];
  logic signed [W-1:0] integNext [ORDER];
  logic signed [W-1:0] combDly   [ORDER];
  logic signed [W-1:0] combOut   [ORDER];
  logic signed [W-1:0] sampleVal;
  logic signed [W-1:0] scaled;

  assign sampleVal = bitIn ? PLUS_ONE : MINUS_ONE;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign integNext[k] = integ[k] + sampleVal;
      assign combOut[k]   = integNext[ORDER-1] - combDly[k];
    end else begin : g_rest
      assign integNext[k] = integ[k] + integNext[k-1];
      assign combOut[k]   = combOut[k-1] - combDly[k];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end else if (strobe.clear) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end else if (strobe.accum) begin
        integ[k] <= integNext[k];
        if (strobe.decim) combDly[k] <= (k == 0) ? integNext[ORDER-1] : combOut[k-1];
      end
    end
  end

  assign scaled = combOut[ORDER-1] <<< normShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.finish) result <= scaled[W-1 -: OUT_W];
    end
  end

  // R3: the done strobe lasts a single cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: no result lies beyond the full-scale value
  p_full_scale_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($signed(result) <= $signed(OUT_W'(1) << (OUT_W-2)) &&
              $signed(result) >= -$signed(OUT_W'(1) << (OUT_W-2))));

  // R6: a start leaves the whole filter empty
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (integ[0] == '0 && integ[ORDER-1] == '0 && combDly[ORDER-1] == '0));
endmodule

// File: rtl/sinc4_incremental_decimator.sv
module sinc4_incremental_decimator
  import sinc4_pkg::*;
#(
  parameter int MAX_LOG2 = 9,
  parameter int MIN_LOG2 = 1,
  parameter int OUT_W = 24,
  localparam int LW = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             sampleEn,
  input  logic             modBit,
  input  logic [LW-1:0]    ratioLog2,
  output logic [OUT_W-1:0] result,
  output logic             resultValid
);
  localparam int W  = 4 * MAX_LOG2 + 2;
  localparam int SW = $clog2(4 * MAX_LOG2 + 1);

  ctlStrobes_t   strobe;
  logic [SW-1:0] normShift;

  sinc4_ctrl #(
    .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2), .LW(LW), .SW(SW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(convStart), .sampleEn(sampleEn),
    .ratioLog2(ratioLog2), .strobe(strobe), .normShift(normShift)
  );

  sinc4_datapath #(
    .W(W), .OUT_W(OUT_W), .SW(SW)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .normShift(normShift),
    .bitIn(modBit), .result(result), .done(resultValid)
  );
endmodule

// File: tb/test_sinc4_incremental_decimator.sv
module test_sinc4_incremental_decimator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b0;
  logic        sampleEn = 1'b0;
  logic        modBit = 1'b0;
  logic [3:0]  ratioLog2 = 4'd9;
  logic [23:0] result;
  logic        resultValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit    bitsArr [0:2047];
  longint hArr   [0:2047];
  longint tmpArr [0:2047];

  sinc4_incremental_decimator i_sinc4_incremental_decimator (
    .clk(clk), .rstN(rstN), .convStart(convStart), .sampleEn(sampleEn),
    .modBit(modBit), .ratioLog2(ratioLog2), .result(result), .resultValid(resultValid)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit patBit(input int pat, input int i);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return i[0];
      3: return ((i * 37 + 5) % 11) < 7;
      default: return (i % 5) == 0;
    endcase
  endfunction

  // Reference: four cascaded boxcars of length R, truncated to 4R taps
  function automatic longint expected(input int l);
    int r = 1 << l;
    int n = 4 * r;
    longint y = 0;
    for (int k = 0; k < n; k++) hArr[k] = (k < r) ? 1 : 0;
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < n; m++) begin
        longint acc = 0;
        for (int j = 0; j < r; j++) if (m - j >= 0) acc += hArr[m-j];
        tmpArr[m] = acc;
      end
      for (int m = 0; m < n; m++) hArr[m] = tmpArr[m];
    end
    for (int k = 0; k < n; k++) y += hArr[k] * (bitsArr[n-1-k] ? 64'sd1 : -64'sd1);
    return (y <<< 22) >>> (4 * l);
  endfunction

  // One full conversion; gap > 0 inserts an idle cycle before every gap-th bit
  task automatic runConv(input int l, input int pat, input int gap, input int altL, input string tag);
    int n = 4 << l;
    bit earlyDone = 1'b0;
    longint exp;
    for (int i = 0; i < n; i++) bitsArr[i] = patBit(pat, i);
    exp = expected(l);
    @(negedge clk);
    convStart = 1'b1; sampleEn = 1'b0; ratioLog2 = 4'(l);
    @(negedge clk);
    convStart = 1'b0;
    if (altL >= 0) ratioLog2 = 4'(altL);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == 0) begin
        sampleEn = 1'b0; modBit = ~bitsArr[i];
        @(negedge clk);
        if (resultValid) earlyDone = 1'b1;
      end
      sampleEn = 1'b1; modBit = bitsArr[i];
      @(negedge clk);
      if (i < n - 1 && resultValid) earlyDone = 1'b1;
    end
    check(!earlyDone, {"R3 no early strobe ", tag}, longint'(earlyDone), 0);
    check(resultValid == 1'b1, {"R3 strobe after last bit ", tag}, longint'(resultValid), 1);
    check(longint'($signed(result)) == exp, {"R5 value ", tag}, longint'($signed(result)), exp);
    sampleEn = 1'b0;
    @(negedge clk);
    check(resultValid == 1'b0, {"R3 strobe one cycle ", tag}, longint'(resultValid), 0);
  endtask

  task automatic testReset();
    check(resultValid == 1'b0, "R1 valid after reset", longint'(resultValid), 0);
    check(result == 24'd0, "R1 result after reset", longint'(result), 0);
  endtask

  task automatic testFullScale();
    runConv(9, 1, 0, -1, "R4 R2 all ones R=512");
    check(result == 24'h400000, "R4 plus full scale", longint'($signed(result)), 64'sh400000);
    runConv(9, 0, 0, -1, "R4 R2 all zeros R=512");
    check(result == 24'hC00000, "R4 minus full scale", longint'($signed(result)), -64'sh400000);
    runConv(2, 1, 0, -1, "R4 all ones R=4");
    check(result == 24'h400000, "R4 plus full scale R=4", longint'($signed(result)), 64'sh400000);
  endtask

  task automatic testMixed();
    runConv(9, 3, 0, -1, "R5 mixed R=512");
    runConv(4, 2, 0, -1, "R5 alternating R=16");
    runConv(1, 3, 0, -1, "R8 R5 smallest ratio R=2");
    runConv(7, 4, 0, -1, "R5 sparse R=128");
  endtask

  task automatic testGaps();
    runConv(6, 3, 3, -1, "R7 idle cycles R=64");
  endtask

  task automatic testRestart();
    @(negedge clk);
    convStart = 1'b1; ratioLog2 = 4'd5;
    @(negedge clk);
    convStart = 1'b0; sampleEn = 1'b1; modBit = 1'b1;
    for (int i = 0; i < 100; i++) @(negedge clk);
    sampleEn = 1'b0;
    runConv(5, 4, 0, -1, "R6 restart mid conversion");
  endtask

  task automatic testRatioChange();
    runConv(3, 3, 0, 9, "R8 ratio change ignored");
  endtask

  task automatic testAfterDone();
    logic [23:0] held;
    bit sawValid = 1'b0;
    runConv(4, 3, 0, -1, "R9 setup");
    held = result;
    sampleEn = 1'b1;
    for (int i = 0; i < 80; i++) begin
      modBit = i[1];
      @(negedge clk);
      if (resultValid) sawValid = 1'b1;
    end
    sampleEn = 1'b0;
    check(!sawValid, "R9 no strobe after done", longint'(sawValid), 0);
    check(result == held, "R9 result held", longint'($signed(result)), longint'($signed(held)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testFullScale();
    testMixed();
    testGaps();
    testRestart();
    testRatioChange();
    testAfterDone();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule